// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Status Word

This block is the integer datapath of a small processor core. Each clock it takes two operands, a five-bit operation code, a width select and a carry input. It computes an add, subtract, increment, decrement, compare, AND, OR, XOR or test, or it runs a single-bit command on the control flags. Results and flags follow either an 8-bit or a 16-bit view of the operands. In the 8-bit view only the low bytes of the operands count.

The unit keeps a 16-bit status word. Six bits of it are arithmetic flags: carry, parity, nibble carry, zero, sign and overflow. Three bits are control flags: step trap, interrupt enable and string direction. A one-cycle write strobe goes out alongside the registered result, so the register file knows when to store it. Compare and test only touch the flags and never raise the strobe.

Everything is registered. The operation issued with the enable high at one rising edge appears on the outputs just after that edge.

Top module: `flag_alu`

## Requirements
- R1: A synchronous active-high reset sets the result to 0, the write strobe to 0 and the status word to 16'h0002.
- R2: The codes 0 (sum), 1 (sum plus carry input), 2 (difference) and 3 (difference minus carry input) produce their result in the selected width: wide=1 is 16 bits and wide=0 is the low 8 bits, with result[15:8]=0. Carry (bit 0) is the carry out of the top bit of the width, or for differences the borrow into it.
- R3: Overflow (bit 11) is set exactly when the two's-complement result of codes 0 to 6 does not fit the selected width.
- R4: Nibble carry (bit 4) is set exactly when codes 0 to 6 produce a carry out of bit 3 or a borrow into it.
- R5: After any arithmetic or logic code, parity (bit 2) is 1 when result bits [7:0] hold an even count of ones, whatever the width. Zero (bit 6) is set when the whole result in the selected width is 0. Sign (bit 7) is the top bit of that width.
- R6: Code 4 adds 1 and code 5 subtracts 1. Both leave carry unchanged.
- R7: Code 6 (compare) sets flags as code 2 would, and code 10 (test) sets flags as AND would. Neither raises the write strobe or changes the result output.
- R8: Codes 7 (AND), 8 (OR), 9 (XOR) and 10 (test) clear carry, overflow and nibble carry.
- R9: The write strobe is 1 for exactly the cycle after an enabled code among 0 to 5 and 7 to 9, and the result output updates in that same cycle.
- R10: Codes 11 and 12 clear and set carry. Codes 13 and 14 clear and set direction (bit 10). Codes 15 and 16 clear and set interrupt enable (bit 9). Codes 17 and 18 clear and set trap (bit 8). Each changes only its own bit and raises no write strobe.
- R11: With enable low, or with an unassigned code (19 to 31), the status word and the result hold and the write strobe is 0.
- R12: Status bit 1 always reads 1. Bits 3, 5 and 12 to 15 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Issue the operation this cycle |
| op | input | 5 | Operation code |
| wide | input | 1 | 1 selects 16-bit, 0 selects 8-bit operation |
| cin | input | 1 | Carry/borrow input for codes 1 and 3 |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| result | output | 16 | Registered result |
| wr | output | 1 | One-cycle result write strobe |
| status | output | 16 | Registered status word |

## Verification
The bench targets the width boundaries: 8'hFF+1 and 16'h7FFF+1, where carry or overflow must come from bit 7 or bit 15 and not from the other one. A unit that took the flags from the wrong width would report carry and overflow for the wrong operation. It checks byte operands with nonzero upper bytes; a unit that leaked them would show a nonzero result[15:8]. Parity is probed with word results whose upper byte has an odd count of ones; a unit that counted all 16 bits would flip the parity bit. It also checks that increment keeps a preset carry, and that compare and test hold the previous result with the strobe low; a unit that got either wrong would lose carry across a loop count or corrupt a register.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBB  = 5'd3,
    OP_INC  = 5'd4,
    OP_DEC  = 5'd5,
    OP_CMP  = 5'd6,
    OP_AND  = 5'd7,
    OP_OR   = 5'd8,
    OP_XOR  = 5'd9,
    OP_TEST = 5'd10,
    OP_CLC  = 5'd11,
    OP_STC  = 5'd12,
    OP_CLD  = 5'd13,
    OP_STD  = 5'd14,
    OP_CLI  = 5'd15,
    OP_STI  = 5'd16,
    OP_CLT  = 5'd17,
    OP_STT  = 5'd18
  } alu_op_e;

  localparam int SW      = 16;
  localparam int B_CARRY = 0;
  localparam int B_PAR   = 2;
  localparam int B_NIB   = 4;
  localparam int B_ZERO  = 6;
  localparam int B_SIGN  = 7;
  localparam int B_TRAP  = 8;
  localparam int B_IEN   = 9;
  localparam int B_DIR   = 10;
  localparam int B_OVF   = 11;

  localparam logic [SW-1:0] ST_FIXED = 16'h0002;
  localparam logic [SW-1:0] ST_LIVE  = 16'h0FD5;

  localparam logic [1:0] LG_AND = 2'd0;
  localparam logic [1:0] LG_OR  = 2'd1;
  localparam logic [1:0] LG_XOR = 2'd2;

endpackage

// File: rtl/flag_alu_arith.sv
module flag_alu_arith #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic          c,
  input  logic          sub,
  input  logic          wide,
  output logic [DW-1:0] sum,
  output logic          cf,
  output logic          af,
  output logic          of
);
  localparam int HW = DW / 2;

  logic [DW-1:0] yv;
  logic          cv;
  logic [DW:0]   full;
  logic [HW:0]   lowf;
  logic          xs, ys, rs;

  always_comb begin
    yv   = sub ? ~y : y;
    cv   = sub ? ~c : c;
    full = {1'b0, x} + {1'b0, yv} + {{DW{1'b0}}, cv};
    lowf = {1'b0, x[HW-1:0]} + {1'b0, yv[HW-1:0]} + {{HW{1'b0}}, cv};
    sum  = wide ? full[DW-1:0] : {{HW{1'b0}}, lowf[HW-1:0]};
    cf   = (wide ? full[DW] : lowf[HW]) ^ sub;
    af   = x[4] ^ y[4] ^ sum[4];
    xs   = wide ? x[DW-1]   : x[HW-1];
    ys   = wide ? yv[DW-1]  : yv[HW-1];
    rs   = wide ? sum[DW-1] : sum[HW-1];
    of   = (xs == ys) && (rs != xs);
  end
endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic [1:0]    sel,
  input  logic          wide,
  output logic [DW-1:0] r
);
  import flag_alu_pkg::*;
  localparam int HW = DW / 2;

  logic [DW-1:0] raw;

  always_comb begin
    case (sel)
      LG_OR:   raw = x | y;
      LG_XOR:  raw = x ^ y;
      default: raw = x & y;
    endcase
    r = wide ? raw : {{HW{1'b0}}, raw[HW-1:0]};
  end
endmodule

// File: rtl/flag_alu_zps.sv
module flag_alu_zps #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] r,
  input  logic          wide,
  output logic          zf,
  output logic          sf,
  output logic          pf
);
  localparam int HW = DW / 2;
  localparam int PW = 8;

  logic lo_zero, hi_zero;

  always_comb begin
    lo_zero = (r[HW-1:0] == '0);
    hi_zero = (r[DW-1:HW] == '0);
    zf = wide ? (lo_zero && hi_zero) : lo_zero;
    sf = wide ? r[DW-1] : r[HW-1];
    pf = ~^r[PW-1:0];
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [4:0]    op,
  input  logic          wide,
  input  logic          cin,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic [DW-1:0] result,
  output logic          wr,
  output logic [15:0]   status
);
  import flag_alu_pkg::*;

  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  alu_op_e       opc;
  logic          do_arith, do_logic, do_sub, keep_cf, wr_op, c_in, y_one;
  logic [1:0]    lsel;
  logic [DW-1:0] y_arg, a_sum, l_res, r_mux;
  logic          a_cf, a_af, a_of, z_f, s_f, p_f;
  logic [15:0]   st_n;

  always_comb begin
    opc      = alu_op_e'(op);
    do_arith = 1'b0;
    do_logic = 1'b0;
    do_sub   = 1'b0;
    keep_cf  = 1'b0;
    wr_op    = 1'b0;
    c_in     = 1'b0;
    y_one    = 1'b0;
    lsel     = LG_AND;
    case (opc)
      OP_ADD:  begin do_arith = 1'b1; wr_op = 1'b1; end
      OP_ADC:  begin do_arith = 1'b1; wr_op = 1'b1; c_in = cin; end
      OP_SUB:  begin do_arith = 1'b1; wr_op = 1'b1; do_sub = 1'b1; end
      OP_SBB:  begin do_arith = 1'b1; wr_op = 1'b1; do_sub = 1'b1; c_in = cin; end
      OP_INC:  begin do_arith = 1'b1; wr_op = 1'b1; y_one = 1'b1; keep_cf = 1'b1; end
      OP_DEC:  begin do_arith = 1'b1; wr_op = 1'b1; y_one = 1'b1; keep_cf = 1'b1; do_sub = 1'b1; end
      OP_CMP:  begin do_arith = 1'b1; do_sub = 1'b1; end
      OP_AND:  begin do_logic = 1'b1; wr_op = 1'b1; lsel = LG_AND; end
      OP_OR:   begin do_logic = 1'b1; wr_op = 1'b1; lsel = LG_OR; end
      OP_XOR:  begin do_logic = 1'b1; wr_op = 1'b1; lsel = LG_XOR; end
      OP_TEST: begin do_logic = 1'b1; lsel = LG_AND; end
      default: ;
    endcase
    y_arg = y_one ? ONE : opb;
  end

  flag_alu_arith #(.DW(DW)) u_arith (
    .x(opa), .y(y_arg), .c(c_in), .sub(do_sub), .wide(wide),
    .sum(a_sum), .cf(a_cf), .af(a_af), .of(a_of)
  );

  flag_alu_logic #(.DW(DW)) u_logic (
    .x(opa), .y(opb), .sel(lsel), .wide(wide), .r(l_res)
  );

  assign r_mux = do_arith ? a_sum : l_res;

  flag_alu_zps #(.DW(DW)) u_zps (
    .r(r_mux), .wide(wide), .zf(z_f), .sf(s_f), .pf(p_f)
  );

  always_comb begin
    st_n = status;
    if (do_arith || do_logic) begin
      st_n[B_ZERO] = z_f;
      st_n[B_SIGN] = s_f;
      st_n[B_PAR]  = p_f;
      st_n[B_NIB]  = do_arith & a_af;
      st_n[B_OVF]  = do_arith & a_of;
      if (!keep_cf) st_n[B_CARRY] = do_arith & a_cf;
    end
    case (opc)
      OP_CLC: st_n[B_CARRY] = 1'b0;
      OP_STC: st_n[B_CARRY] = 1'b1;
      OP_CLD: st_n[B_DIR]   = 1'b0;
      OP_STD: st_n[B_DIR]   = 1'b1;
      OP_CLI: st_n[B_IEN]   = 1'b0;
      OP_STI: st_n[B_IEN]   = 1'b1;
      OP_CLT: st_n[B_TRAP]  = 1'b0;
      OP_STT: st_n[B_TRAP]  = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      wr     <= 1'b0;
      status <= ST_FIXED;
    end else begin
      wr <= en && wr_op;
      if (en) begin
        status <= (st_n & ST_LIVE) | ST_FIXED;
        if (wr_op) result <= r_mux;
      end
    end
  end
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic [4:0]    op,
  input logic          wide,
  input logic [DW-1:0] result,
  input logic          wr,
  input logic [15:0]   status
);
  import flag_alu_pkg::*;
  localparam int HW = DW / 2;

  logic wr_code, logic_code, noflag_code;
  assign wr_code     = (op <= OP_DEC) || (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  assign logic_code  = (op >= OP_AND) && (op <= OP_TEST);
  assign noflag_code = (op > OP_STT);

  assert_strobe_src_R9: assert property (@(posedge clk) disable iff (rst)
    (en && wr_code) |=> wr);
  assert_strobe_only_R9: assert property (@(posedge clk) disable iff (rst)
    !(en && wr_code) |=> !wr);
  assert_flagonly_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (en && (op == OP_CMP || op == OP_TEST)) |=> $stable(result));
  assert_inc_keeps_cf_R6: assert property (@(posedge clk) disable iff (rst)
    (en && (op == OP_INC || op == OP_DEC)) |=> $stable(status[B_CARRY]));
  assert_logic_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (en && logic_code) |=> (!status[B_CARRY] && !status[B_OVF] && !status[B_NIB]));
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!en || noflag_code) |=> ($stable(status) && $stable(result)));
  assert_byte_upper_R2: assert property (@(posedge clk) disable iff (rst)
    (en && wr_code && !wide) |=> (result[DW-1:HW] == '0));
  assert_set_carry_R10: assert property (@(posedge clk) disable iff (rst)
    (en && op == OP_STC) |=> status[B_CARRY]);
  assert_fixed_bits_R12: assert property (@(posedge clk) disable iff (rst)
    (status & ~ST_LIVE) == ST_FIXED);
endmodule

bind flag_alu flag_alu_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .en(en), .op(op), .wide(wide),
  .result(result), .wr(wr), .status(status)
);

// File: tb/sim_flag_alu.sv
module sim_flag_alu;
  logic        clk = 1'b0;
  logic        rst, en, wide, cin;
  logic [4:0]  op;
  logic [15:0] opa, opb;
  logic [15:0] result, status;
  logic        wr;

  always #4 clk = ~clk;

  flag_alu u0 (
    .clk(clk), .rst(rst), .en(en), .op(op), .wide(wide), .cin(cin),
    .opa(opa), .opb(opb), .result(result), .wr(wr), .status(status)
  );

  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;
  logic [15:0] e_res = 16'h0000;
  logic [15:0] e_st  = 16'h0002;
  logic        e_wr  = 1'b0;

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model(int o, bit w, int a, int b, bit c, bit e);
    int mask, half, msb, x, y, r, sx, sy, s, cc;
    bit ar, lg, wrt, keep, sb, cf, af, of;
    logic [7:0] lb;
    mask = w ? 'hFFFF : 'hFF;
    half = mask >> 1;
    msb  = w ? 15 : 7;
    x = a & mask; y = b & mask;
    ar = 0; lg = 0; wrt = 0; keep = 0; sb = 0; cc = 0; r = 0;
    e_wr = 1'b0;
    if (!e) return;
    case (o)
      0: begin ar = 1; wrt = 1; end
      1: begin ar = 1; wrt = 1; cc = c; end
      2: begin ar = 1; wrt = 1; sb = 1; end
      3: begin ar = 1; wrt = 1; sb = 1; cc = c; end
      4: begin ar = 1; wrt = 1; y = 1; keep = 1; end
      5: begin ar = 1; wrt = 1; y = 1; keep = 1; sb = 1; end
      6: begin ar = 1; sb = 1; end
      7: begin lg = 1; wrt = 1; r = x & y; end
      8: begin lg = 1; wrt = 1; r = x | y; end
      9: begin lg = 1; wrt = 1; r = x ^ y; end
      10: begin lg = 1; r = x & y; end
      11: e_st[0] = 1'b0;
      12: e_st[0] = 1'b1;
      13: e_st[10] = 1'b0;
      14: e_st[10] = 1'b1;
      15: e_st[9] = 1'b0;
      16: e_st[9] = 1'b1;
      17: e_st[8] = 1'b0;
      18: e_st[8] = 1'b1;
      default: ;
    endcase
    if (ar) begin
      sx = (x > half) ? x - mask - 1 : x;
      sy = (y > half) ? y - mask - 1 : y;
      if (!sb) begin
        r  = (x + y + cc) & mask;
        cf = (x + y + cc) > mask;
        af = ((x & 15) + (y & 15) + cc) > 15;
        s  = sx + sy + cc;
      end else begin
        r  = (x - y - cc) & mask;
        cf = x < (y + cc);
        af = (x & 15) < ((y & 15) + cc);
        s  = sx - sy - cc;
      end
      of = (s > half) || (s < -half - 1);
    end else begin
      cf = 0; af = 0; of = 0;
    end
    if (ar || lg) begin
      if (!keep) e_st[0] = cf;
      e_st[4]  = af;
      e_st[11] = of;
      e_st[6]  = (r == 0);
      e_st[7]  = ((r >> msb) & 1) != 0;
      lb       = r[7:0];
      e_st[2]  = ~^lb;
    end
    if (wrt) e_res = r[15:0];
    e_wr = wrt;
  endtask

  task automatic run(int o, bit w, int a, int b, bit c, bit e, string tag);
    @(negedge clk);
    en = e; op = o[4:0]; wide = w; opa = a[15:0]; opb = b[15:0]; cin = c;
    model(o, w, a, b, c, e);
    @(negedge clk);
    chk(tag, "result", result, e_res);
    chk(tag, "wr", {15'd0, wr}, {15'd0, e_wr});
    chk(tag, "status", status, e_st);
    en = 1'b0;
  endtask

  function automatic string tag_of(int o, bit e);
    if (!e || o > 18) return "R11";
    if (o <= 3) return "R2";
    if (o <= 5) return "R6";
    if (o == 6 || o == 10) return "R7";
    if (o <= 9) return "R8";
    return "R10";
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; en = 1'b0; op = '0; wide = 1'b0; cin = 1'b0; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "result", result, 16'h0000);
    chk("R1", "wr", {15'd0, wr}, 16'h0000);
    chk("R1", "status", status, 16'h0002);
    // R2 byte carry out of bit 7, upper operand bytes ignored
    run(0, 0, 'h12FF, 'h3401, 0, 1, "R2");
    run(0, 0, 'h1234, 'h5678, 0, 1, "R2");
    run(3, 1, 'h1000, 'h0FFF, 1, 1, "R2");
    // R3 signed overflow at word and byte boundary
    run(0, 1, 'h7FFF, 'h0001, 0, 1, "R3");
    run(2, 0, 'h0080, 'h0001, 0, 1, "R3");
    // R4 nibble borrow
    run(2, 0, 'h0010, 'h0001, 0, 1, "R4");
    // R5 parity only over low byte
    run(9, 1, 'h0700, 'h0400, 0, 1, "R5");
    run(9, 1, 'h0301, 'h0200, 0, 1, "R5");
    // R6 increment keeps a set carry
    run(12, 0, 0, 0, 0, 1, "R10");
    run(4, 1, 'hFFFF, 0, 0, 1, "R6");
    run(5, 0, 'h0000, 0, 0, 1, "R6");
    // R7 compare and test leave result alone
    run(6, 1, 'h4242, 'h4242, 0, 1, "R7");
    run(10, 0, 'h00F0, 'h000F, 0, 1, "R7");
    // R8 logic clears carry
    run(12, 0, 0, 0, 0, 1, "R10");
    run(7, 1, 'hFFFF, 'h8001, 0, 1, "R8");
    // R9 strobe falls when idle
    run(0, 1, 1, 1, 0, 0, "R9");
    // R10 control flags
    for (int k = 11; k <= 18; k++) run(k, 0, 0, 0, 0, 1, "R10");
    for (int k = 17; k >= 11; k--) run(k, 1, 0, 0, 0, 1, "R10");
    // R11 unassigned code and disabled issue
    run(25, 1, 'hFFFF, 1, 1, 1, "R11");
    run(2, 1, 5, 9, 0, 0, "R11");
    for (int i = 0; i < 1500; i++) begin
      int o;
      bit e;
      o = $urandom_range(0, 21);
      e = ($urandom_range(0, 7) != 0);
      run(o, $urandom_range(0, 1), $urandom_range(0, 65535),
          ($urandom_range(0, 3) == 0) ? $urandom_range(0, 3) : $urandom_range(0, 65535),
          $urandom_range(0, 1), e, tag_of(o, e));
      // R12 fixed status bits
      chk("R12", "fixed bits", status & 16'hF02A, 16'h0002);
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule